// File: doc/BRIEF.md
# Iterative 8-bit multiply/divide unit

A sequential arithmetic unit for an 8-bit stack machine. It reads its two operands from the machine's top-of-stack and next-of-stack registers and returns the two result bytes to be written back into those same registers. A single-cycle start request begins either an unsigned multiply or an unsigned divide. The operation select is bit 0 of the instruction byte: 0xEC selects multiply and 0xED selects divide. Every operation takes the same fixed number of cycles, regardless of the operand values.

Inside, a radix-2 shift datapath does one bit per cycle. A multiply uses add-and-shift steps, and a divide uses restoring steps. The unit then waits out the rest of the fixed latency and writes both result bytes on the same edge as a one-cycle done pulse. On that same cycle it also presents a cleared carry flag to the machine. In every other cycle the carry output passes the machine's carry value through.

Top module: `md_unit`

## Requirements
- R1: After reset, tos_o, next_o, carry_o, done_o, busy_o and div_err_o are all 0.
- R2: A start_i sampled high at a rising edge while busy_o is low is accepted. busy_o is then high for the next 13 cycles. done_o goes high after the 13th rising edge following the accepting edge, so the done cycle is the 14th cycle counting the accepting one. done_o stays high for exactly one cycle, and busy_o is low during it.
- R3: With op_i = 0 (multiply), the 16-bit unsigned product tos_i * next_i is delivered with its high byte on tos_o and its low byte on next_o.
- R4: With op_i = 1 (divide) and tos_i nonzero, next_i is divided by tos_i as unsigned integers. The quotient appears on next_o and the remainder on tos_o.
- R5: A divide with tos_i = 0 gives next_o = 0 and tos_o = the dividend next_i. It also sets div_err_o, which stays 1 until reset.
- R6: A start_i that arrives while busy_o is high is ignored. Operands are not recaptured, and neither the done timing nor the results of the running operation change.
- R7: tos_o and next_o change only in the done cycle. They hold their values in every other cycle, whatever happens on tos_i and next_i.
- R8: carry_o is 0 in the done cycle. In every other cycle it equals carry_i delayed by one clock.
- R9: A start_i sampled at the edge that ends the done cycle is accepted, so operations can run back to back every 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled each rising edge |
| op_i | input | 1 | Operation select: 0 multiply, 1 divide (opcode bit 0) |
| tos_i | input | 8 | Top-of-stack operand (multiplier or divisor) |
| next_i | input | 8 | Next-of-stack operand (multiplicand or dividend) |
| carry_i | input | 1 | Current carry flag of the machine |
| tos_o | output | 8 | Result for top of stack (product high byte or remainder) |
| next_o | output | 8 | Result for next of stack (product low byte or quotient) |
| carry_o | output | 1 | Carry flag to write back, cleared in the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| div_err_o | output | 1 | Sticky divide-by-zero flag |

## Verification
The hardest case to reach is a start request that lands in the middle of a running operation and carries different operands and a different op select. The stimulus injects such a request partway through a multiply. It then confirms that the done cycle and the product still belong to the first request, and that no second completion follows. A second hard case is the boundary where a new start coincides with the done cycle. This is covered by issuing the next operation in exactly that cycle and checking its latency and result. Divide-by-zero is followed by a normal divide, which shows that the error flag persists while the arithmetic recovers.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/md_seq.sv
module md_seq #(
  parameter int LATENCY = 14,
  parameter int STEPS   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign accept_o = start_i && !busy_q;
  assign step_o   = busy_q && (cnt_q <= CW'(STEPS));
  assign fin_o    = busy_q && (cnt_q == CW'(LATENCY - 1));
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= CW'(1);
      busy_q <= 1'b1;
    end else if (fin_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/md_core.sv
module md_core
  import md_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  md_op_e       op_i,
  input  logic [W-1:0] tos_i,
  input  logic [W-1:0] next_i,
  output md_op_e       op_o,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] opnd_o,
  output logic [W-1:0] dvd_o
);
  md_op_e       op_q;
  logic [W-1:0] acc_q, lo_q, opnd_q, dvd_q;

  // multiply: add-and-shift
  logic [W:0]   mul_sum;
  // divide: restoring step, two guard bits for the borrow
  logic [W:0]   rem_ext;
  logic [W+1:0] diff;
  logic         fits;

  assign mul_sum = {1'b0, acc_q} + (lo_q[0] ? {1'b0, opnd_q} : '0);
  assign rem_ext = {acc_q, lo_q[W-1]};
  assign diff    = {1'b0, rem_ext} - {2'b00, opnd_q};
  assign fits    = !diff[W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_MUL;
      acc_q  <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
      dvd_q  <= '0;
    end else if (load_i) begin
      op_q  <= op_i;
      acc_q <= '0;
      dvd_q <= next_i;
      if (op_i == OP_MUL) begin
        lo_q   <= tos_i;
        opnd_q <= next_i;
      end else begin
        lo_q   <= next_i;
        opnd_q <= tos_i;
      end
    end else if (step_i) begin
      if (op_q == OP_MUL) begin
        acc_q <= mul_sum[W:1];
        lo_q  <= {mul_sum[0], lo_q[W-1:1]};
      end else if (fits) begin
        acc_q <= diff[W-1:0];
        lo_q  <= {lo_q[W-2:0], 1'b1};
      end else begin
        acc_q <= rem_ext[W-1:0];
        lo_q  <= {lo_q[W-2:0], 1'b0};
      end
    end
  end

  assign op_o   = op_q;
  assign acc_o  = acc_q;
  assign lo_o   = lo_q;
  assign opnd_o = opnd_q;
  assign dvd_o  = dvd_q;
endmodule

// File: rtl/md_wb.sv
module md_wb
  import md_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fin_i,
  input  md_op_e       op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] dvd_i,
  input  logic         carry_i,
  output logic [W-1:0] tos_o,
  output logic [W-1:0] next_o,
  output logic         carry_o,
  output logic         done_o,
  output logic         err_o
);
  logic div_zero;
  assign div_zero = (op_i == OP_DIV) && (opnd_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_o   <= '0;
      next_o  <= '0;
      carry_o <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o  <= fin_i;
      carry_o <= fin_i ? 1'b0 : carry_i;
      if (fin_i) begin
        if (div_zero) begin
          tos_o  <= dvd_i;
          next_o <= '0;
          err_o  <= 1'b1;
        end else begin
          // mul: acc=high, lo=low; div: acc=remainder, lo=quotient
          tos_o  <= acc_i;
          next_o <= lo_i;
        end
      end
    end
  end
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int W       = 8,
  parameter int LATENCY = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_i,
  input  logic [W-1:0] tos_i,
  input  logic [W-1:0] next_i,
  input  logic         carry_i,
  output logic [W-1:0] tos_o,
  output logic [W-1:0] next_o,
  output logic         carry_o,
  output logic         done_o,
  output logic         busy_o,
  output logic         div_err_o
);
  localparam int STEPS = W;

  logic         accept, step, fin;
  md_op_e       op_q;
  logic [W-1:0] acc, lo, opnd, dvd;

  md_seq #(.LATENCY(LATENCY), .STEPS(STEPS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .step_o  (step),
    .fin_o   (fin),
    .busy_o  (busy_o)
  );

  md_core #(.W(W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .step_i(step),
    .op_i  (md_op_e'(op_i)),
    .tos_i (tos_i),
    .next_i(next_i),
    .op_o  (op_q),
    .acc_o (acc),
    .lo_o  (lo),
    .opnd_o(opnd),
    .dvd_o (dvd)
  );

  md_wb #(.W(W)) u_wb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fin_i  (fin),
    .op_i   (op_q),
    .acc_i  (acc),
    .lo_i   (lo),
    .opnd_i (opnd),
    .dvd_i  (dvd),
    .carry_i(carry_i),
    .tos_o  (tos_o),
    .next_o (next_o),
    .carry_o(carry_o),
    .done_o (done_o),
    .err_o  (div_err_o)
  );
endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int W       = 8,
  parameter int LATENCY = 14
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         op_i,
  input logic [W-1:0] tos_i,
  input logic [W-1:0] next_i,
  input logic [W-1:0] tos_o,
  input logic [W-1:0] next_o,
  input logic         carry_o,
  input logic         done_o,
  input logic         busy_o,
  input logic         div_err_o
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0] age_q;
  logic          cap_op;
  logic [W-1:0]  cap_t, cap_n;
  logic [2*W-1:0] prod;

  assign prod = {{W{1'b0}}, cap_t} * {{W{1'b0}}, cap_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= '0;
      cap_op <= 1'b0;
      cap_t  <= '0;
      cap_n  <= '0;
    end else if (start_i && !busy_o) begin
      age_q  <= CW'(1);
      cap_op <= op_i;
      cap_t  <= tos_i;
      cap_n  <= next_i;
    end else if (age_q != '0 && age_q != CW'(LATENCY)) begin
      age_q  <= age_q + CW'(1);
    end else begin
      age_q  <= '0;
    end
  end

  // R2 R6 R9: completion exactly LATENCY cycles after an accepted start
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (age_q == CW'(LATENCY)));

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_mul_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cap_op) |-> ({tos_o, next_o} == prod));

  assert_div_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op && cap_t != '0) |-> (next_o == cap_n / cap_t && tos_o == cap_n % cap_t));

  assert_div_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op && cap_t == '0) |-> (next_o == '0 && tos_o == cap_n && div_err_o));

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |=> div_err_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(tos_o) && $stable(next_o)));

  assert_carry_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !carry_o);
endmodule

bind md_unit md_unit_chk #(.W(W), .LATENCY(LATENCY)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .tos_i    (tos_i),
  .next_i   (next_i),
  .tos_o    (tos_o),
  .next_o   (next_o),
  .carry_o  (carry_o),
  .done_o   (done_o),
  .busy_o   (busy_o),
  .div_err_o(div_err_o)
);

// File: tb/md_unit_test.sv
module md_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       op_i = 1'b0;
  logic [7:0] tos_i = '0;
  logic [7:0] next_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] tos_o, next_o;
  logic       carry_o, done_o, busy_o, div_err_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  md_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .tos_i(tos_i), .next_i(next_i), .carry_i(carry_i),
    .tos_o(tos_o), .next_o(next_o), .carry_o(carry_o),
    .done_o(done_o), .busy_o(busy_o), .div_err_o(div_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // Called at a negedge; returns at the negedge inside the done cycle.
  task automatic run_op(input logic op, input logic [7:0] t, input logic [7:0] n,
                        output int lat);
    op_i = op; tos_i = t; next_i = n; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    tos_i = ~t; next_i = ~n;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk_i);
      if (done_o) begin lat = k; break; end
    end
  endtask

  task automatic t_reset;
    check("R1 tos_o", tos_o, 0);
    check("R1 next_o", next_o, 0);
    check("R1 flags", {carry_o, done_o, busy_o, div_err_o}, 0);
  endtask

  task automatic t_mul(input logic [7:0] t, input logic [7:0] n);
    int lat;
    int p;
    p = t * n;
    idle(1);
    run_op(1'b0, t, n, lat);
    check("R2 latency", lat, 13);
    check("R2 busy low at done", busy_o, 0);
    check("R3 product", {tos_o, next_o}, p);
    @(negedge clk_i);
    check("R2 done single cycle", done_o, 0);
  endtask

  task automatic t_div(input logic [7:0] t, input logic [7:0] n);
    int lat;
    idle(1);
    run_op(1'b1, t, n, lat);
    check("R2 latency div", lat, 13);
    check("R4 quotient", next_o, n / t);
    check("R4 remainder", tos_o, n % t);
  endtask

  task automatic t_div_zero;
    int lat;
    idle(1);
    run_op(1'b1, 8'h00, 8'd77, lat);
    check("R5 quotient zero", next_o, 0);
    check("R5 remainder is dividend", tos_o, 77);
    check("R5 err set", div_err_o, 1);
    idle(2);
    run_op(1'b1, 8'd6, 8'd45, lat);
    check("R5 err sticky", div_err_o, 1);
    check("R5 recover", {tos_o, next_o}, {8'd3, 8'd7});
  endtask

  task automatic t_busy_ignore;
    int lat;
    idle(1);
    op_i = 1'b0; tos_i = 8'd3; next_i = 8'd4; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      if (k == 5) begin
        op_i = 1'b1; tos_i = 8'd2; next_i = 8'd99; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      if (k == 3) check("R6 busy during op", busy_o, 1);
      if (done_o) begin lat = k; break; end
    end
    start_i = 1'b0;
    check("R6 latency unchanged", lat, 13);
    check("R6 result of first op", {tos_o, next_o}, 12);
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_i);
      if (done_o) lat = k;
    end
    check("R6 no second done", lat, 0);
  endtask

  task automatic t_hold;
    logic [15:0] held;
    held = {tos_o, next_o};
    for (int i = 0; i < 6; i++) begin
      tos_i = 8'(i * 37); next_i = 8'(i * 11 + 5);
      @(negedge clk_i);
    end
    check("R7 outputs held while idle", {tos_o, next_o}, held);
  endtask

  task automatic t_carry;
    int lat;
    idle(1);
    carry_i = 1'b1;
    @(negedge clk_i);
    check("R8 carry passes", carry_o, 1);
    run_op(1'b0, 8'd9, 8'd9, lat);
    check("R8 carry cleared at done", carry_o, 0);
    @(negedge clk_i);
    check("R8 carry follows after done", carry_o, 1);
    carry_i = 1'b0;
    @(negedge clk_i);
    check("R8 carry follows low", carry_o, 0);
  endtask

  task automatic t_back_to_back;
    int lat;
    idle(1);
    run_op(1'b0, 8'd20, 8'd30, lat);
    check("R9 first result", {tos_o, next_o}, 600);
    run_op(1'b1, 8'd9, 8'd100, lat);
    check("R9 second latency", lat, 13);
    check("R9 second result", {tos_o, next_o}, {8'd1, 8'd11});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_mul(8'd13, 8'd17);
    t_mul(8'hFF, 8'hFF);
    t_mul(8'h00, 8'hA5);
    t_mul(8'h80, 8'h02);
    t_div(8'd7, 8'd200);
    t_div(8'd9, 8'd5);
    t_div(8'd1, 8'd255);
    t_div(8'd3, 8'd0);
    t_div(8'hFF, 8'hFF);
    t_busy_ignore();
    t_hold();
    t_carry();
    t_back_to_back();
    t_div_zero();
    idle(2);
    finished = 1;
    summary();
    $finish;
  end
endmodule